// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a down-counting timer with a programmable power-of-two prescaler. Software loads a starting value and the counter steps down once every 2^shift base clocks. In one-shot mode it runs to zero and holds there. In periodic mode it reloads the starting value after zero, so the period is the starting value plus one prescaled ticks. Each expiry raises a one-clock pulse toward the interrupt logic, and a mask bit can suppress that pulse.

Four registers sit on a simple write port. A separate combinational read port returns their contents and the live count. The divide setting uses a three-bit code that is not contiguous in the register: two low bits plus one higher bit. The prescale shift is that code plus one, wrapping at eight, so the all-ones code means divide-by-1.

Top module: `prescaled_down_timer`

## Requirements
- R1: A write to the divide register (select 3) keeps only bits 0, 1 and 3, and the register reads back as the written value ANDed with 0xB.
- R2: The divide code is {bit3, bit1, bit0} and the shift is (code + 1) mod 8. The count steps down once every 2^shift clocks, so code 7 steps every clock and code 0 every two clocks.
- R3: In one-shot mode (control bit 17 clear), a starting value N > 0 counts down to zero, stays at zero, and produces exactly one expiry pulse. The pulse follows the prescaled tick after the one that reached zero, i.e. (N+1)·2^shift clocks after the load edge.
- R4: In periodic mode (control bit 17 set), the count goes from zero back to N on the next tick. An expiry pulse accompanies every wrap, so pulses come every (N+1)·2^shift clocks.
- R5: While the mask bit (control bit 16) is set, no expiry pulse is produced, and counting carries on unchanged.
- R6: A write to the starting-value register (select 1) reloads the count and clears the prescaler phase in the same edge. Timing restarts from that edge.
- R7: A starting value of zero never produces an expiry in either mode, and the count stays at zero.
- R8: After reset the control register reads 0x00010000 (masked, one-shot), and the divide register, the starting value and the current count read zero.
- R9: Writes to the current-count select (2) have no effect on the count.
- R10: The expiry output is high for exactly one clock per expiry. It rises in the cycle after the clock edge on which the expiring tick occurs.
- R11: The control register keeps only bits 16 and 17, and every other bit reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write select: 0 control, 1 starting value, 2 current count, 3 divide |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 2 | Read select, same encoding as wrAddr |
| rdData | output | DATA_W | Combinational readback of the selected register |
| curCount | output | CNT_W | Live count value |
| expire | output | 1 | One-clock expiry pulse |

## Verification
The bench builds the block with CNT_W = 8 and keeps DATA_W at 32. This leaves the full divide decode in place and makes the widest starting value, 255, cheap to run. All eight divide codes are swept against starting values 0, 1 and 3, in both modes, masked and unmasked. For each case the count and the pulse are compared every cycle against closed-form arithmetic on the clock index since the load. A reload in the middle of a prescale phase, the all-ones starting value and writes outside the kept bits are also covered.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_DIV  = 2'd3
  } regSel_e;

  localparam int PERIODIC_BIT = 17;
  localparam int MASK_BIT     = 16;
  localparam int SHIFT_W      = 3;
  localparam logic [3:0] DIV_KEEP = 4'hB;

  typedef struct packed {
    logic               loadInit;
    logic               periodic;
    logic               masked;
    logic [SHIFT_W-1:0] shift;
  } tmrCmd_t;

  function automatic logic [SHIFT_W-1:0] divToShift(input logic [3:0] divVal);
    logic [SHIFT_W-1:0] code;
    code = {divVal[3], divVal[1:0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  input  logic [CNT_W-1:0]  curCount,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  initVal,
  output logic [CNT_W-1:0]  loadVal,
  output tmrCmd_t           cmd
);
  logic       periodicReg;
  logic       maskReg;
  logic [3:0] divReg;
  logic       wrCtrl, wrInit, wrDiv;

  assign wrCtrl = wrEn && (regSel_e'(wrAddr) == SEL_CTRL);
  assign wrInit = wrEn && (regSel_e'(wrAddr) == SEL_INIT);
  assign wrDiv  = wrEn && (regSel_e'(wrAddr) == SEL_DIV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodicReg <= 1'b0;
      maskReg     <= 1'b1;
      divReg      <= 4'd0;
      initVal     <= '0;
    end else begin
      if (wrCtrl) begin
        periodicReg <= wrData[PERIODIC_BIT];
        maskReg     <= wrData[MASK_BIT];
      end
      if (wrDiv)  divReg  <= wrData[3:0] & DIV_KEEP;
      if (wrInit) initVal <= wrData[CNT_W-1:0];
    end
  end

  assign loadVal = wrData[CNT_W-1:0];

  always_comb begin
    cmd.loadInit = wrInit;
    cmd.periodic = periodicReg;
    cmd.masked   = maskReg;
    cmd.shift    = divToShift(divReg);
  end

  always_comb begin
    rdData = '0;
    unique case (regSel_e'(rdAddr))
      SEL_CTRL: begin
        rdData[PERIODIC_BIT] = periodicReg;
        rdData[MASK_BIT]     = maskReg;
      end
      SEL_INIT: rdData[CNT_W-1:0] = initVal;
      SEL_CUR:  rdData[CNT_W-1:0] = curCount;
      SEL_DIV:  rdData[3:0]       = divReg;
      default:  rdData = '0;
    endcase
  end

  // R1
  div_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDiv |=> (divReg == ($past(wrData[3:0]) & 4'hB)));

  // R11
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (periodicReg == $past(wrData[PERIODIC_BIT]) && maskReg == $past(wrData[MASK_BIT])));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  input  logic [CNT_W-1:0] initVal,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             tick;
  logic             atZero;
  logic             armed;
  logic             fire;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      preLimit[i] = (i < int'(cmd.shift));
    end
  end

  assign tick   = (preCnt >= preLimit);
  assign atZero = (count == '0);
  assign fire   = tick && atZero && !cmd.masked &&
                  (cmd.periodic ? (initVal != '0) : armed);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
      armed  <= 1'b0;
      expire <= 1'b0;
    end else if (cmd.loadInit) begin
      preCnt <= '0;
      count  <= loadVal;
      armed  <= (loadVal != '0);
      expire <= 1'b0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      expire <= fire;
      if (tick) begin
        if (!atZero) begin
          count <= count - 1'b1;
        end else if (cmd.periodic) begin
          count <= initVal;
        end else begin
          armed <= 1'b0;
        end
      end
    end
  end

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !expire);

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> !$past(cmd.masked));

  // R3
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.loadInit && !cmd.periodic && atZero) |=> (count == '0));

  // R4
  periodic_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.loadInit && cmd.periodic && tick && atZero) |=> (count == $past(initVal)));

  // R2
  step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.loadInit && !tick) |=> $stable(count));
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  curCount,
  output logic              expire
);
  tmrCmd_t          cmd;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] loadVal;

  tmr_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .curCount(curCount), .rdData(rdData),
    .initVal(initVal), .loadVal(loadVal), .cmd(cmd)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .initVal(initVal), .loadVal(loadVal),
    .count(curCount), .expire(expire)
  );
endmodule

// File: tb/prescaled_down_timer_bench.sv
module prescaled_down_timer_bench;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrAddr = 2'd0;
  logic [DATA_W-1:0] wrData = '0;
  logic [1:0]        rdAddr = 2'd0;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0]  curCount;
  logic              expire;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prescaled_down_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_prescaled_down_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .curCount(curCount), .expire(expire)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int sel, input logic [DATA_W-1:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(sel); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(input int sel, input logic [DATA_W-1:0] exp, input string req);
    rdAddr = 2'(sel);
    #1;
    chk(rdData == exp, req, rdData, exp);
  endtask

  // Called at the negedge right after the load edge (k = 0).
  task automatic observe(input int n, input int p, input bit per, input bit msk,
                         input int cycles, input string req);
    int pulses;
    int expPulses;
    pulses = 0;
    for (int k = 0; k <= cycles; k++) begin
      int t;
      int expCnt;
      bit expExp;
      if (k > 0) @(negedge clk);
      t = k / p;
      if (per) expCnt = (n == 0) ? 0 : n - (t % (n + 1));
      else     expCnt = (t >= n) ? 0 : n - t;
      expExp = (k > 0) && (k % p == 0) && !msk && (n != 0) &&
               (per ? (t % (n + 1) == 0) : (t == n + 1));
      chk(curCount == CNT_W'(expCnt), {req, " R2 count"}, curCount, expCnt);
      chk(expire == expExp, {req, " R10 pulse"}, expire, expExp);
      if (expire) pulses++;
    end
    if (msk || n == 0) expPulses = 0;
    else if (per) expPulses = cycles / ((n + 1) * p);
    else expPulses = 1;
    chk(pulses == expPulses, {req, " pulse total"}, pulses, expPulses);
  endtask

  task automatic runCase(input int n, input int code, input bit per, input bit msk);
    logic [DATA_W-1:0] dv;
    int p;
    int cycles;
    string req;
    dv = '0;
    dv[3] = code[2];
    dv[1:0] = code[1:0];
    p = 1 << ((code + 1) % 8);
    cycles = per ? 3 * (n + 1) * p + 2 : (n + 3) * p + 2;
    if (n == 0) req = "R7";
    else if (msk) req = "R5";
    else if (per) req = "R4";
    else req = "R3";
    writeReg(3, dv);
    writeReg(0, (DATA_W'(per) << 17) | (DATA_W'(msk) << 16));
    writeReg(1, DATA_W'(n));
    observe(n, p, per, msk, cycles, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    readChk(0, 32'h0001_0000, "R8 ctrl");
    readChk(1, 32'h0, "R8 init");
    readChk(2, 32'h0, "R8 cur");
    readChk(3, 32'h0, "R8 div");
    chk(expire == 1'b0, "R8 expire", expire, 0);

    // R1 divide keeps bits 0,1,3
    writeReg(3, 32'hFFFF_FFFF);
    readChk(3, 32'h0000_000B, "R1");
    writeReg(3, 32'h0000_0004);
    readChk(3, 32'h0000_0000, "R1");
    // R11 control keeps bits 16,17
    writeReg(0, 32'hFFFF_FFFF);
    readChk(0, 32'h0003_0000, "R11");
    writeReg(0, 32'h0002_0000);
    readChk(0, 32'h0002_0000, "R11");

    // R2..R5, R7, R10 sweep
    for (int code = 0; code < 8; code++) begin
      foreach (sweepN[i]) begin
        for (int per = 0; per < 2; per++) begin
          for (int msk = 0; msk < 2; msk++) begin
            runCase(sweepN[i], code, bit'(per), bit'(msk));
          end
        end
      end
    end
    // largest starting value, divide-by-1, one-shot (R3)
    runCase((1 << CNT_W) - 1, 7, 1'b0, 1'b0);

    // R6 reload mid-phase restarts count and prescaler
    writeReg(3, 32'h0);
    writeReg(0, 32'h0);
    writeReg(1, 32'd9);
    repeat (5) @(negedge clk);
    writeReg(1, 32'd4);
    observe(4, 2, 1'b0, 1'b0, 16, "R6");
    readChk(1, 32'd4, "R6 init readback");

    // R9 current-count writes ignored
    writeReg(0, 32'h0001_0000);
    writeReg(1, 32'd0);
    writeReg(2, 32'h0000_0055);
    chk(curCount == 0, "R9 count", curCount, 0);
    readChk(2, 32'h0, "R9 readback");
    writeReg(0, 32'h0002_0000);
    writeReg(1, 32'd200);
    writeReg(2, 32'h0000_0003);
    chk(curCount == 8'd199, "R9 running count", curCount, 199);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int sweepN [3] = '{0, 1, 3};
endmodule